// File: doc/BRIEF.md
# Interval Performance History Monitor

This block keeps a rolling record of line-quality events for a digital transmission line. A per-second classifier upstream raises a one-cycle strobe whenever a second is judged unavailable, bursty errored, severely errored, errored, a controlled-slip second, or a loss-of-frame event. The block adds these strobes into 15-minute interval accumulators. When an interval-end strobe arrives, it writes the accumulators into a 96-entry circular history and clears them for the next interval. Running day accumulators are snapshotted into day-total registers on a day-end strobe. A tally records how many intervals hold valid data.

A host reads the data one byte at a time. It chooses a counter group with `rd_sel` and pulses `rd_start`. Each `rd_next` pulse then steps to the high byte of the current word, and after that to the next older history entry. Every counter saturates and never wraps. The slip and frame-loss counts are two 8-bit fields packed into one 16-bit word.

Top module: `perf_history_mon`

## Requirements
- R1: After reset, every history read returns zero, the valid-interval tally and all day totals read zero, and the read pointer sits at index 0 on the low byte.
- R2: On `ivl_end`, the interval accumulators are written to the history head and cleared. An event strobe in the same cycle as `ivl_end` is counted in the new interval, not in the committed one.
- R3: Read index k returns the entry committed k intervals before the most recent commit (k=0 is the newest). An index at or above the valid-interval tally reads zero.
- R4: The 16-bit counters (interval and day unavailable, bursty and severely errored, and day errored seconds) stop at 65535 and never roll over.
- R5: The packed slip/frame-loss word carries the controlled-slip count in bits 7:0 and the loss-of-frame count in bits 15:8. Each field stops at 255.
- R6: On `day_end`, the running day accumulators are copied into the day-total registers and restarted. An event in the same cycle as `day_end` counts toward the new day.
- R7: The valid-interval tally rises by one on each `ivl_end`, stops at 96, and is cleared only by reset.
- R8: Reads are byte-serial with the low byte first. `rd_start` sets index 0 on the low byte. `rd_next` moves from the low byte to the high byte, and from the high byte to the low byte of index k+1. Index 95 is followed by index 0. `rd_start` takes precedence over `rd_next`.
- R9: `rd_sel` encoding:
  - 0–3 select the history of unavailable, bursty errored, severely errored, and slip/frame-loss.
  - 4–8 select the day totals of errored, unavailable, bursty errored, severely errored, and slip/frame-loss.
  - 9 selects the valid-interval tally, zero-extended.
  - 10–15 read zero.
- R10: The history keeps only the 96 most recent intervals. The 97th commit overwrites the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_es | input | 1 | Errored-second strobe |
| ev_uas | input | 1 | Unavailable-second strobe |
| ev_bes | input | 1 | Bursty-errored-second strobe |
| ev_ses | input | 1 | Severely-errored-second strobe |
| ev_css | input | 1 | Controlled-slip-second strobe |
| ev_lof | input | 1 | Loss-of-frame strobe |
| ivl_end | input | 1 | Interval-end strobe |
| day_end | input | 1 | Day-end strobe, given with the 96th interval-end |
| rd_sel | input | 4 | Counter group select |
| rd_start | input | 1 | Restart read at newest entry, low byte |
| rd_next | input | 1 | Advance read by one byte |
| rd_byte | output | 8 | Selected byte of the selected word |
| rd_idx | output | 7 | Current history read index |
| rd_hi | output | 1 | High-byte phase flag |

## Verification
The assertions assume that `day_end` is only ever raised in the same cycle as `ivl_end`. They also assume that every strobe is a plain level sampled once per clock, so holding a strobe high counts one event per cycle. The bench respects both assumptions: it raises `day_end` only inside its interval-commit task, and it never drives `rd_start` and `rd_next` together. Saturation is reached by holding strobes high for more cycles than the counters can hold, which stays within the one-event-per-cycle model.

// File: rtl/phm_pkg.sv
package phm_pkg;

  typedef enum logic [3:0] {
    SEL_H_UAS  = 4'd0,
    SEL_H_BES  = 4'd1,
    SEL_H_SES  = 4'd2,
    SEL_H_SLIP = 4'd3,
    SEL_D_ES   = 4'd4,
    SEL_D_UAS  = 4'd5,
    SEL_D_BES  = 4'd6,
    SEL_D_SES  = 4'd7,
    SEL_D_SLIP = 4'd8,
    SEL_VALID  = 4'd9
  } sel_e;

  // Physical slot holding the entry k steps behind the newest one.
  function automatic int unsigned ring_addr(int unsigned head, int unsigned k,
                                            int unsigned depth);
    int unsigned s;
    s = head + depth - 1 - k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Next write pointer position, wrapping at depth.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/phm_sat_ctr.sv
module phm_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         roll,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  localparam logic [W-1:0] MAXV = '1;

  assign at_max = (cnt == MAXV);

  // On roll the counter restarts; a coincident event seeds the new period.
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (roll)          cnt <= {{(W-1){1'b0}}, inc};
    else if (inc && !at_max) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/phm_hist_bank.sv
module phm_hist_bank #(
  parameter int DEPTH = 96,
  parameter int W     = 16,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/perf_history_mon.sv
module perf_history_mon #(
  parameter int DEPTH = 96,
  parameter int FW    = 8,
  parameter int VW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_es,
  input  logic                     ev_uas,
  input  logic                     ev_bes,
  input  logic                     ev_ses,
  input  logic                     ev_css,
  input  logic                     ev_lof,
  input  logic                     ivl_end,
  input  logic                     day_end,
  input  logic [3:0]               rd_sel,
  input  logic                     rd_start,
  input  logic                     rd_next,
  output logic [FW-1:0]            rd_byte,
  output logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     rd_hi
);
  import phm_pkg::*;

  localparam int CW    = 2 * FW;
  localparam int AW    = $clog2(DEPTH);
  localparam int NWIDE = 3;   // wide interval groups: uas, bes, ses
  localparam int NHIST = NWIDE + 1;
  localparam int NDAYW = 4;   // wide day groups: es, uas, bes, ses

  // Named events for the checker.
  logic commit, day_roll;
  assign commit   = ivl_end;
  assign day_roll = day_end;

  // Interval accumulators.
  logic [NWIDE-1:0] ivl_inc;
  logic [CW-1:0]    ivl_acc [NWIDE];
  logic [NWIDE-1:0] ivl_max;
  assign ivl_inc = {ev_ses, ev_bes, ev_uas};

  for (genvar g = 0; g < NWIDE; g++) begin : g_ivl
    phm_sat_ctr #(.W(CW)) ctr_i (
      .clk(clk), .rst_n(rst_n), .inc(ivl_inc[g]), .roll(commit),
      .cnt(ivl_acc[g]), .at_max(ivl_max[g]));
  end

  logic [FW-1:0] ivl_css, ivl_lof;
  logic          ivl_css_max, ivl_lof_max;
  phm_sat_ctr #(.W(FW)) ivl_css_i (
    .clk(clk), .rst_n(rst_n), .inc(ev_css), .roll(commit),
    .cnt(ivl_css), .at_max(ivl_css_max));
  phm_sat_ctr #(.W(FW)) ivl_lof_i (
    .clk(clk), .rst_n(rst_n), .inc(ev_lof), .roll(commit),
    .cnt(ivl_lof), .at_max(ivl_lof_max));

  logic [CW-1:0] uas_ivl;
  assign uas_ivl = ivl_acc[0];

  // Running day accumulators.
  logic [NDAYW-1:0] day_inc;
  logic [CW-1:0]    day_run [NDAYW];
  logic [NDAYW-1:0] day_max;
  assign day_inc = {ev_ses, ev_bes, ev_uas, ev_es};

  for (genvar g = 0; g < NDAYW; g++) begin : g_day
    phm_sat_ctr #(.W(CW)) ctr_i (
      .clk(clk), .rst_n(rst_n), .inc(day_inc[g]), .roll(day_roll),
      .cnt(day_run[g]), .at_max(day_max[g]));
  end

  logic [FW-1:0] day_css, day_lof;
  logic          day_css_max, day_lof_max;
  phm_sat_ctr #(.W(FW)) day_css_i (
    .clk(clk), .rst_n(rst_n), .inc(ev_css), .roll(day_roll),
    .cnt(day_css), .at_max(day_css_max));
  phm_sat_ctr #(.W(FW)) day_lof_i (
    .clk(clk), .rst_n(rst_n), .inc(ev_lof), .roll(day_roll),
    .cnt(day_lof), .at_max(day_lof_max));

  // Day-total snapshot: four wide totals plus the packed slip word.
  logic [CW-1:0] day_q [NDAYW+1];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= NDAYW; i++) day_q[i] <= '0;
    end else if (day_roll) begin
      for (int i = 0; i < NDAYW; i++) day_q[i] <= day_run[i];
      day_q[NDAYW] <= {day_lof, day_css};
    end
  end

  // History ring and valid tally.
  logic [AW-1:0] wptr;
  logic [VW-1:0] vcnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      vcnt <= '0;
    end else if (commit) begin
      wptr <= AW'(ring_next(32'(wptr), DEPTH));
      if (32'(vcnt) < DEPTH) vcnt <= vcnt + 1'b1;
    end
  end

  // Read sequencing.
  logic [AW-1:0] rd_k;
  logic          rd_ph;
  always_ff @(posedge clk) begin
    if (!rst_n || rd_start) begin
      rd_k  <= '0;
      rd_ph <= 1'b0;
    end else if (rd_next) begin
      rd_ph <= ~rd_ph;
      if (rd_ph) rd_k <= AW'(ring_next(32'(rd_k), DEPTH));
    end
  end

  logic [AW-1:0] raddr;
  logic          in_range;
  assign raddr    = AW'(ring_addr(32'(wptr), 32'(rd_k), DEPTH));
  assign in_range = 32'(rd_k) < 32'(vcnt);

  logic [CW-1:0] hist_wdata [NHIST];
  logic [CW-1:0] hist_rdata [NHIST];
  for (genvar g = 0; g < NHIST; g++) begin : g_hist
    if (g < NWIDE) begin : g_w
      assign hist_wdata[g] = ivl_acc[g];
    end else begin : g_s
      assign hist_wdata[g] = {ivl_lof, ivl_css};
    end
    phm_hist_bank #(.DEPTH(DEPTH), .W(CW), .AW(AW)) bank_i (
      .clk(clk), .we(commit), .waddr(wptr), .wdata(hist_wdata[g]),
      .raddr(raddr), .rdata(hist_rdata[g]));
  end

  logic [CW-1:0] rd_word;
  always_comb begin
    case (sel_e'(rd_sel))
      SEL_H_UAS:  rd_word = in_range ? hist_rdata[0] : '0;
      SEL_H_BES:  rd_word = in_range ? hist_rdata[1] : '0;
      SEL_H_SES:  rd_word = in_range ? hist_rdata[2] : '0;
      SEL_H_SLIP: rd_word = in_range ? hist_rdata[3] : '0;
      SEL_D_ES:   rd_word = day_q[0];
      SEL_D_UAS:  rd_word = day_q[1];
      SEL_D_BES:  rd_word = day_q[2];
      SEL_D_SES:  rd_word = day_q[3];
      SEL_D_SLIP: rd_word = day_q[4];
      SEL_VALID:  rd_word = CW'(vcnt);
      default:    rd_word = '0;
    endcase
  end

  assign rd_byte = rd_ph ? rd_word[CW-1:FW] : rd_word[FW-1:0];
  assign rd_idx  = rd_k;
  assign rd_hi   = rd_ph;

  // Saturation flags are part of the counter interface; fold them away.
  logic unused_flags;
  assign unused_flags = ^{ivl_max, ivl_css_max, ivl_lof_max, day_max,
                          day_css_max, day_lof_max};
endmodule

// File: rtl/phm_chk.sv
module phm_chk #(
  parameter int DEPTH = 96,
  parameter int CW    = 16,
  parameter int AW    = 7,
  parameter int VW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit,
  input logic          day_roll,
  input logic          ev_uas,
  input logic          rd_start,
  input logic [AW-1:0] wptr,
  input logic [VW-1:0] vcnt,
  input logic [AW-1:0] rd_k,
  input logic          rd_ph,
  input logic [CW-1:0] uas_ivl
);
  localparam logic [CW-1:0] MAXV = '1;

  AST_DAY_WITH_IVL: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |-> commit);                                          // R6
  AST_VCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vcnt) <= DEPTH);                                           // R7
  AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit && 32'(vcnt) < DEPTH |=> 32'(vcnt) == 32'($past(vcnt)) + 1); // R7
  AST_VCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(vcnt));                                    // R7
  AST_WPTR_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> 32'(wptr) == ((32'($past(wptr)) == DEPTH - 1) ? 0 : 32'($past(wptr)) + 1)); // R10
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !ev_uas |=> uas_ivl == '0);                          // R2
  AST_ACC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    commit && ev_uas |=> uas_ivl == 1);                            // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    uas_ivl == MAXV && !commit |=> uas_ivl == MAXV);               // R4
  AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> rd_k == '0 && !rd_ph);                            // R8
  AST_K_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rd_k) < DEPTH);                                            // R8
endmodule

bind perf_history_mon phm_chk #(
  .DEPTH(DEPTH), .CW(CW), .AW(AW), .VW(VW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit), .day_roll(day_roll),
  .ev_uas(ev_uas), .rd_start(rd_start), .wptr(wptr), .vcnt(vcnt),
  .rd_k(rd_k), .rd_ph(rd_ph), .uas_ivl(uas_ivl)
);

// File: tb/perf_history_mon_tb.sv
module perf_history_mon_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_es = 0, ev_uas = 0, ev_bes = 0, ev_ses = 0, ev_css = 0, ev_lof = 0;
  logic ivl_end = 0, day_end = 0, rd_start = 0, rd_next = 0;
  logic [3:0] rd_sel = '0;
  logic [7:0] rd_byte;
  logic [6:0] rd_idx;
  logic       rd_hi;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  perf_history_mon dut_i (
    .clk(clk), .rst_n(rst_n), .ev_es(ev_es), .ev_uas(ev_uas), .ev_bes(ev_bes),
    .ev_ses(ev_ses), .ev_css(ev_css), .ev_lof(ev_lof), .ivl_end(ivl_end),
    .day_end(day_end), .rd_sel(rd_sel), .rd_start(rd_start), .rd_next(rd_next),
    .rd_byte(rd_byte), .rd_idx(rd_idx), .rd_hi(rd_hi));

  // Per interval: uas, bes, ses, css, lof, es event counts.
  localparam int NV = 4;
  localparam int VEC [NV][6] = '{
    '{3, 1, 2, 5, 0, 4},
    '{0, 7, 1, 2, 3, 9},
    '{10, 0, 0, 0, 1, 2},
    '{2, 2, 2, 2, 2, 2}
  };

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input int u, input int b, input int s, input int c,
                       input int l, input int e);
    int n;
    n = u;
    if (b > n) n = b;
    if (s > n) n = s;
    if (c > n) n = c;
    if (l > n) n = l;
    if (e > n) n = e;
    for (int i = 0; i < n; i++) begin
      ev_uas = (i < u); ev_bes = (i < b); ev_ses = (i < s);
      ev_css = (i < c); ev_lof = (i < l); ev_es = (i < e);
      @(negedge clk);
    end
    {ev_uas, ev_bes, ev_ses, ev_css, ev_lof, ev_es} = '0;
  endtask

  task automatic commit(input logic day, input logic co);
    ivl_end = 1; day_end = day; ev_uas = co; ev_es = co;
    @(negedge clk);
    ivl_end = 0; day_end = 0; ev_uas = 0; ev_es = 0;
  endtask

  task automatic read_entry(input int sel, input int k, output int word);
    int lo;
    rd_sel = 4'(sel);
    rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    for (int j = 0; j < 2 * k; j++) begin
      rd_next = 1;
      @(negedge clk);
    end
    rd_next = 0;
    lo = int'(rd_byte);
    rd_next = 1;
    @(negedge clk);
    rd_next = 0;
    word = (int'(rd_byte) << 8) | lo;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 idx", int'(rd_idx), 0);
    check("R1 phase", int'(rd_hi), 0);
    read_entry(9, 0, w); check("R1 valid", w, 0);
    read_entry(0, 0, w); check("R1 hist", w, 0);
    read_entry(5, 0, w); check("R1 day", w, 0);

    // Vector table: R2 commit, R3 newest first, R5 packing
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      commit(0, 0);
    end
    for (int k = 0; k < NV; k++) begin
      for (int g = 0; g < 3; g++) begin
        read_entry(g, k, w); check("R3 hist newest-first", w, VEC[NV-1-k][g]);
      end
      read_entry(3, k, w);
      check("R5 packed slip/lof", w, (VEC[NV-1-k][4] << 8) | VEC[NV-1-k][3]);
    end
    read_entry(0, NV, w); check("R3 beyond valid", w, 0);
    read_entry(9, 0, w); check("R7 valid 4", w, 4);
    read_entry(12, 0, w); check("R9 unused sel", w, 0);

    // R6 day totals on an empty interval commit
    commit(1, 0);
    read_entry(4, 0, w); check("R6 day es", w, 17);
    read_entry(5, 0, w); check("R6 day uas", w, 15);
    read_entry(6, 0, w); check("R6 day bes", w, 10);
    read_entry(7, 0, w); check("R6 day ses", w, 5);
    read_entry(8, 0, w); check("R5 R6 day slip", w, (6 << 8) | 9);
    read_entry(0, 0, w); check("R2 empty interval", w, 0);

    // R2/R6 coincident events go to the new period
    apply(2, 0, 0, 0, 0, 0);
    commit(1, 1);
    read_entry(0, 0, w); check("R2 coincident excluded", w, 2);
    read_entry(5, 0, w); check("R6 coincident excluded", w, 2);
    read_entry(4, 0, w); check("R6 day es excl", w, 0);
    commit(1, 0);
    read_entry(0, 0, w); check("R2 credited to new", w, 1);
    read_entry(0, 1, w); check("R3 older entry", w, 2);
    read_entry(4, 0, w); check("R6 day es new day", w, 1);
    read_entry(9, 0, w); check("R7 valid 7", w, 7);

    // R4/R5 saturation
    ev_uas = 1; ev_es = 1; ev_lof = 1;
    repeat (65540) @(negedge clk);
    ev_uas = 0; ev_es = 0; ev_lof = 0;
    commit(1, 0);
    read_entry(0, 0, w); check("R4 hist uas sat", w, 65535);
    read_entry(4, 0, w); check("R4 day es sat", w, 65535);
    read_entry(3, 0, w); check("R5 lof field sat", w, 16'hFF00);
    read_entry(8, 0, w); check("R5 day lof sat", w, 16'hFF00);

    // R10 ring wrap after a fresh reset
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    read_entry(9, 0, w); check("R1 valid after reset", w, 0);
    read_entry(4, 0, w); check("R1 day after reset", w, 0);
    for (int i = 0; i < 100; i++) begin
      apply((i % 5) + 1, 0, 0, 0, 0, 0);
      commit(0, 0);
    end
    read_entry(9, 0, w); check("R7 valid sat 96", w, 96);
    read_entry(0, 0, w); check("R10 newest", w, 5);
    read_entry(0, 94, w); check("R10 k94", w, 1);
    read_entry(0, 95, w); check("R10 oldest kept", w, 5);
    // R8 index wraps from 95 back to 0 on the low byte
    rd_next = 1;
    @(negedge clk);
    rd_next = 0;
    check("R8 wrap idx", int'(rd_idx), 0);
    check("R8 wrap phase", int'(rd_hi), 0);
    check("R8 wrap byte", int'(rd_byte), 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule